// File: doc/BRIEF.md
# USB Bulk/Interrupt IN Endpoint Engine

This block runs one Bulk or Interrupt IN endpoint. Firmware pushes payload bytes into a local FIFO through a simple strobe interface and then arms the endpoint. When the packet layer reports an IN token, the engine either answers with a NAK (not armed) or streams a DATA packet toward the serializer, one byte per cycle, tagged with the current data PID. It then waits for the transaction outcome. An ACK completes the packet, and a timeout leaves it armed for an identical resend.

Completion raises a sticky done flag, which firmware clears with a write-one-to-clear strobe. The flag is gated onto an interrupt line by an enable bit. If firmware drops the arm flag before the host acknowledges, the packet is cancelled and the FIFO is emptied. Arming with an empty FIFO produces a zero-length packet. CRC, bit-level encoding and token decoding live elsewhere.

Top module: `inEndpointEngine`

## Requirements
- R1: After reset, txReady, txDone, irq, hsNak, pktStart and byteValid are 0, byteCount is 0, and pktPid is 0.
- R2: While epEnable is 0, an inToken pulse produces neither hsNak nor pktStart.
- R3: With epEnable high and txReady low, an inToken pulse gives a one-cycle hsNak in the cycle after the token, and no packet.
- R4: With txReady high, an inToken pulse gives pktStart in the next cycle. The stored bytes appear on byteData with byteValid on consecutive cycles, starting in the pktStart cycle, in write order. byteLast is high on the final byte only, and the packet length equals the number of accepted writes.
- R5: Arming with byteCount 0 gives a pktStart pulse with no byteValid cycle, which is a zero-length packet.
- R6: A fwClrReady pulse while armed cancels the packet. txReady drops, byteCount returns to 0, a later ackIn is ignored (txDone stays 0), the next token is NAKed, and the PID is unchanged.
- R7: An ackIn pulse after a packet sets txDone, clears txReady, empties the FIFO, and toggles the PID.
- R8: A timeoutIn pulse after a packet keeps txReady high. The next token resends the same bytes with the same PID.
- R9: Writes are dropped while txDone is 1, while txReady is 1, or when byteCount equals DEPTH (64 by default).
- R10: irq equals txDone AND irqEnable. A fwClrDone pulse clears txDone.
- R11: pktPid is 0 for DATA0 and 1 for DATA1. It is DATA0 after reset and after epEnable has been low.
- R12: fwSetReady is ignored while txDone is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| epEnable | input | 1 | Endpoint enabled and configured |
| irqEnable | input | 1 | Interrupt enable |
| fwWrEn | input | 1 | Firmware FIFO write strobe |
| fwWrData | input | 8 | Firmware write byte |
| fwSetReady | input | 1 | Arm the endpoint |
| fwClrReady | input | 1 | Disarm and flush (cancel) |
| fwClrDone | input | 1 | Write-one-to-clear of txDone |
| txReady | output | 1 | Endpoint armed |
| txDone | output | 1 | Packet acknowledged |
| irq | output | 1 | Interrupt request |
| byteCount | output | CW | Bytes held in the FIFO |
| inToken | input | 1 | IN token for this endpoint (pulse) |
| ackIn | input | 1 | Host ACK received (pulse) |
| timeoutIn | input | 1 | No handshake received (pulse) |
| hsNak | output | 1 | Send NAK handshake (pulse) |
| pktStart | output | 1 | DATA packet begins (pulse) |
| pktPid | output | 1 | Data PID, 0 for DATA0 and 1 for DATA1 |
| byteValid | output | 1 | byteData carries a payload byte |
| byteData | output | 8 | Payload byte |
| byteLast | output | 1 | Final payload byte |

## Verification
The bench sweeps every packet length from zero to a full FIFO. For each length it checks the byte order, the last marker and the alternating PID. A design that miscounts would lose or repeat the final byte, or toggle the PID on the wrong event. It retries a packet after a timeout and expects identical data and PID; a design that advanced its read pointer or toggled early would fail this. It cancels an armed packet and then sends a stray ACK, which catches designs that keep stale bytes or flip the PID on a cancelled send. It also tries writes and arming in the forbidden states, including an overfull write, where a leaky design would grow byteCount or arm a completed endpoint.

// File: rtl/inEpPkg.sv
package inEpPkg;

  typedef enum logic [1:0] {
    EP_IDLE  = 2'd0,
    EP_ARMED = 2'd1,
    EP_SEND  = 2'd2,
    EP_WAIT  = 2'd3
  } epState_t;

  typedef struct packed {
    logic push;
    logic flush;
    logic rdRestart;
    logic rdNext;
  } fifoCmd_t;

endpackage

// File: rtl/inEpFifo.sv
module inEpFifo
  import inEpPkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  fifoCmd_t      cmd,
  input  logic [7:0]    wrData,
  output logic [7:0]    rdData,
  output logic [CW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          lastByte
);

  logic [7:0]    mem [DEPTH];
  logic [CW-1:0] count;
  logic [CW-1:0] rdPtr;

  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign level    = count;
  assign rdData   = mem[rdPtr[AW-1:0]];
  assign lastByte = ((rdPtr + CW'(1)) == count);

  always_ff @(posedge clk) begin
    if (cmd.push && !full) mem[count[AW-1:0]] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (cmd.flush) begin
      count <= '0;
    end else if (cmd.push && !full) begin
      count <= count + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
    end else if (cmd.flush || cmd.rdRestart) begin
      rdPtr <= '0;
    end else if (cmd.rdNext) begin
      rdPtr <= rdPtr + CW'(1);
    end
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));

  // R4
  read_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.rdNext |-> (rdPtr < count));

  // R6
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.flush |=> (count == '0));

endmodule

// File: rtl/inEpCtrl.sv
module inEpCtrl
  import inEpPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     epEnable,
  input  logic     irqEnable,
  input  logic     fwWrEn,
  input  logic     fwSetReady,
  input  logic     fwClrReady,
  input  logic     fwClrDone,
  input  logic     inToken,
  input  logic     ackIn,
  input  logic     timeoutIn,
  input  logic     full,
  input  logic     empty,
  input  logic     lastByte,
  output fifoCmd_t cmd,
  output logic     txReady,
  output logic     txDone,
  output logic     irq,
  output logic     hsNak,
  output logic     pktStart,
  output logic     pktPid,
  output logic     byteValid,
  output logic     byteLast
);

  epState_t state, stateNxt;
  logic doneQ, toggleQ, nakQ, startQ;
  logic cancel, acked, timedOut, tokenOk;

  assign tokenOk  = inToken && epEnable;
  assign cancel   = fwClrReady && (state != EP_IDLE);
  assign acked    = (state == EP_WAIT) && ackIn && !fwClrReady;
  assign timedOut = (state == EP_WAIT) && timeoutIn && !fwClrReady;

  always_comb begin
    cmd.push      = fwWrEn && (state == EP_IDLE) && !doneQ && !full;
    cmd.flush     = cancel || acked;
    cmd.rdRestart = timedOut;
    cmd.rdNext    = (state == EP_SEND) && !fwClrReady;
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      EP_IDLE:  if (fwSetReady && !doneQ) stateNxt = EP_ARMED;
      EP_ARMED: begin
        if (fwClrReady)   stateNxt = EP_IDLE;
        else if (tokenOk) stateNxt = empty ? EP_WAIT : EP_SEND;
      end
      EP_SEND: begin
        if (fwClrReady)    stateNxt = EP_IDLE;
        else if (lastByte) stateNxt = EP_WAIT;
      end
      EP_WAIT: begin
        if (fwClrReady || ackIn) stateNxt = EP_IDLE;
        else if (timeoutIn)      stateNxt = EP_ARMED;
      end
      default: stateNxt = EP_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= EP_IDLE;
      doneQ   <= 1'b0;
      toggleQ <= 1'b0;
      nakQ    <= 1'b0;
      startQ  <= 1'b0;
    end else begin
      state  <= stateNxt;
      nakQ   <= tokenOk && (state == EP_IDLE);
      startQ <= tokenOk && (state == EP_ARMED) && !fwClrReady;
      if (acked)          doneQ <= 1'b1;
      else if (fwClrDone) doneQ <= 1'b0;
      if (!epEnable)  toggleQ <= 1'b0;
      else if (acked) toggleQ <= ~toggleQ;
    end
  end

  assign txReady   = (state != EP_IDLE);
  assign txDone    = doneQ;
  assign irq       = doneQ && irqEnable;
  assign hsNak     = nakQ;
  assign pktStart  = startQ;
  assign pktPid    = toggleQ;
  assign byteValid = (state == EP_SEND);
  assign byteLast  = (state == EP_SEND) && lastByte;

  // R2
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(epEnable) |-> (!hsNak && !pktStart));

  // R3
  nak_no_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    hsNak |-> (!pktStart && !byteValid));

  // R8
  retry_same_pid_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((state == EP_WAIT) && timeoutIn && !ackIn && !fwClrReady && epEnable)
      |=> (txReady && pktPid == $past(pktPid)));

  // R7
  ack_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((state == EP_WAIT) && ackIn && !fwClrReady && epEnable)
      |=> (txDone && !txReady && pktPid != $past(pktPid)));

  // R6
  cancel_disarm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fwClrReady && txReady) |=> !txReady);

  // R12
  no_arm_when_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txDone && !txReady) |=> !txReady);

endmodule

// File: rtl/inEndpointEngine.sv
module inEndpointEngine
  import inEpPkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          epEnable,
  input  logic          irqEnable,
  input  logic          fwWrEn,
  input  logic [7:0]    fwWrData,
  input  logic          fwSetReady,
  input  logic          fwClrReady,
  input  logic          fwClrDone,
  output logic          txReady,
  output logic          txDone,
  output logic          irq,
  output logic [CW-1:0] byteCount,
  input  logic          inToken,
  input  logic          ackIn,
  input  logic          timeoutIn,
  output logic          hsNak,
  output logic          pktStart,
  output logic          pktPid,
  output logic          byteValid,
  output logic [7:0]    byteData,
  output logic          byteLast
);

  fifoCmd_t cmd;
  logic full, empty, lastByte;

  inEpCtrl ctrl (
    .clk(clk), .rstN(rstN), .epEnable(epEnable), .irqEnable(irqEnable),
    .fwWrEn(fwWrEn), .fwSetReady(fwSetReady), .fwClrReady(fwClrReady),
    .fwClrDone(fwClrDone), .inToken(inToken), .ackIn(ackIn),
    .timeoutIn(timeoutIn), .full(full), .empty(empty), .lastByte(lastByte),
    .cmd(cmd), .txReady(txReady), .txDone(txDone), .irq(irq),
    .hsNak(hsNak), .pktStart(pktStart), .pktPid(pktPid),
    .byteValid(byteValid), .byteLast(byteLast)
  );

  inEpFifo #(.DEPTH(DEPTH)) fifo (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wrData(fwWrData),
    .rdData(byteData), .level(byteCount), .full(full), .empty(empty),
    .lastByte(lastByte)
  );

endmodule

// File: tb/inEndpointEngine_test.sv
module inEndpointEngine_test;

  localparam int DEPTH = 64;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN, epEnable, irqEnable, fwWrEn, fwSetReady, fwClrReady, fwClrDone;
  logic [7:0] fwWrData;
  logic inToken, ackIn, timeoutIn;
  logic txReady, txDone, irq, hsNak, pktStart, pktPid, byteValid, byteLast;
  logic [7:0] byteData;
  logic [CW-1:0] byteCount;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [7:0] rxBuf [0:127];
  int rxN, lastCnt, lastIdx;
  bit sawNak, sawStart, rxPid;
  bit expPid = 0;

  always #4 clk = ~clk;

  inEndpointEngine #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .epEnable(epEnable), .irqEnable(irqEnable),
    .fwWrEn(fwWrEn), .fwWrData(fwWrData), .fwSetReady(fwSetReady),
    .fwClrReady(fwClrReady), .fwClrDone(fwClrDone), .txReady(txReady),
    .txDone(txDone), .irq(irq), .byteCount(byteCount), .inToken(inToken),
    .ackIn(ackIn), .timeoutIn(timeoutIn), .hsNak(hsNak), .pktStart(pktStart),
    .pktPid(pktPid), .byteValid(byteValid), .byteData(byteData),
    .byteLast(byteLast)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wrByte(input logic [7:0] d);
    fwWrEn = 1'b1; fwWrData = d;
    @(negedge clk);
    fwWrEn = 1'b0;
  endtask

  task automatic setReady();
    fwSetReady = 1'b1; @(negedge clk); fwSetReady = 1'b0;
  endtask

  task automatic clrReady();
    fwClrReady = 1'b1; @(negedge clk); fwClrReady = 1'b0;
  endtask

  task automatic clrDone();
    fwClrDone = 1'b1; @(negedge clk); fwClrDone = 1'b0;
  endtask

  task automatic sendAck();
    ackIn = 1'b1; @(negedge clk); ackIn = 1'b0;
  endtask

  task automatic sendTimeout();
    timeoutIn = 1'b1; @(negedge clk); timeoutIn = 1'b0;
  endtask

  // Pulse a token and record the engine's response over the following cycles.
  task automatic doToken();
    rxN = 0; lastCnt = 0; lastIdx = -1; sawNak = 0; sawStart = 0; rxPid = 0;
    inToken = 1'b1;
    @(negedge clk);
    inToken = 1'b0;
    for (int k = 0; k < DEPTH + 4; k++) begin
      if (hsNak) sawNak = 1;
      if (pktStart) begin sawStart = 1; rxPid = pktPid; end
      if (byteValid) begin
        if (byteLast) begin lastCnt++; lastIdx = rxN; end
        rxBuf[rxN] = byteData;
        rxN++;
      end
      @(negedge clk);
    end
  endtask

  function automatic logic [7:0] pat(input int len, input int i);
    return 8'((len * 7 + i * 13 + 5) & 255);
  endfunction

  task automatic checkPacket(input string req, input int len, input bit pid);
    int errs = 0;
    check(sawStart && !sawNak, req, sawStart, 1);
    check(rxPid == pid, req, rxPid, pid);
    check(rxN == len, req, rxN, len);
    for (int i = 0; i < len && i < rxN; i++) if (rxBuf[i] !== pat(len, i)) errs++;
    check(errs == 0, req, errs, 0);
    if (len == 0) check(lastCnt == 0, req, lastCnt, 0);
    else check(lastCnt == 1 && lastIdx == len - 1, req, lastIdx, len - 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 0; epEnable = 0; irqEnable = 0; fwWrEn = 0; fwWrData = 0;
    fwSetReady = 0; fwClrReady = 0; fwClrDone = 0;
    inToken = 0; ackIn = 0; timeoutIn = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    check(!txReady && !txDone && !irq, "R1", {txReady, txDone, irq}, 0);
    check(byteCount == 0 && !pktPid, "R1", byteCount, 0);
    check(!hsNak && !pktStart && !byteValid, "R1", {hsNak, pktStart, byteValid}, 0);

    // R2 disabled endpoint ignores tokens
    doToken();
    check(!sawNak && !sawStart, "R2", {sawNak, sawStart}, 0);

    epEnable = 1; irqEnable = 1;
    @(negedge clk);

    // R3 unarmed token gets NAK
    doToken();
    check(sawNak && !sawStart && rxN == 0, "R3", {sawNak, sawStart}, 2);

    // R4 / R8 / R7 with a 5 byte packet, one timeout then ACK
    for (int i = 0; i < 5; i++) wrByte(pat(5, i));
    check(byteCount == 5, "R4", byteCount, 5);
    setReady();
    check(txReady, "R4", txReady, 1);
    doToken();
    checkPacket("R4", 5, 0);
    sendTimeout();
    check(txReady && !txDone, "R8", {txReady, txDone}, 2);
    doToken();
    checkPacket("R8", 5, 0);
    sendAck();
    check(txDone && !txReady && byteCount == 0, "R7", {txDone, txReady}, 2);
    check(irq, "R10", irq, 1);
    expPid = 1;

    // R9 writes dropped while done; R12 arm ignored while done
    wrByte(8'hA5);
    check(byteCount == 0, "R9", byteCount, 0);
    setReady();
    check(!txReady, "R12", txReady, 0);
    irqEnable = 0;
    @(negedge clk);
    check(!irq, "R10", irq, 0);
    irqEnable = 1;
    clrDone();
    check(!txDone && !irq, "R10", {txDone, irq}, 0);

    // R9 writes dropped while armed
    for (int i = 0; i < 2; i++) wrByte(pat(2, i));
    setReady();
    wrByte(8'h3C);
    check(byteCount == 2, "R9", byteCount, 2);
    doToken();
    checkPacket("R9", 2, expPid);
    sendAck();
    expPid = ~expPid;
    clrDone();

    // R6 cancel after data sent, then a stray ACK
    for (int i = 0; i < 3; i++) wrByte(pat(3, i));
    setReady();
    doToken();
    checkPacket("R6", 3, expPid);
    clrReady();
    check(!txReady && byteCount == 0, "R6", {txReady, byteCount}, 0);
    sendAck();
    check(!txDone, "R6", txDone, 0);
    doToken();
    check(sawNak && !sawStart, "R6", {sawNak, sawStart}, 2);

    // R4 / R5 / R9 sweep over every length including empty and full
    for (int len = 0; len <= DEPTH; len++) begin
      for (int i = 0; i < len; i++) wrByte(pat(len, i));
      if (len == DEPTH) begin
        wrByte(8'hFF);
        check(byteCount == DEPTH, "R9", byteCount, DEPTH);
      end
      setReady();
      doToken();
      checkPacket(len == 0 ? "R5" : "R4", len, expPid);
      sendAck();
      check(txDone && byteCount == 0, "R7", {txDone, byteCount}, 2);
      expPid = ~expPid;
      clrDone();
    end

    // R11 PID returns to DATA0 after disable; make it DATA1 first if needed
    if (expPid == 0) begin
      wrByte(pat(1, 0)); setReady(); doToken(); sendAck(); clrDone();
    end
    epEnable = 0;
    @(negedge clk);
    epEnable = 1;
    @(negedge clk);
    check(!pktPid, "R11", pktPid, 0);
    wrByte(pat(1, 0));
    setReady();
    doToken();
    checkPacket("R11", 1, 0);
    sendAck();
    clrDone();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule